// File: doc/BRIEF.md
# Corner-Turn Line Buffer

This block sits between a 256-element bit-serial processing array and a 16-bit word bus and reorganises data between the two shapes. Each instance is built for one direction. In the word-to-plane direction it gathers sixteen 16-bit words and presents them to the array as one 256-bit bit-plane. In the plane-to-word direction it takes one 256-bit plane from the array and hands it out as sixteen 16-bit words. A chip that needs both directions on a channel, or several channels, places one instance for each direction of each channel.

Storage is split into two halves used in ping-pong fashion. One half fills while the other drains, so word traffic on the bus overlaps with plane traffic at the array. The halves change roles only when the filling half is complete and the draining half is empty, or is giving up its last beat in that cycle. Both sides use a valid/ready handshake. A stall on either side holds the data in place and loses nothing.

Top module: `corner_turn_buf`

## Requirements
- R1: In word-to-plane mode, 16 accepted words form one 256-bit plane. Word k, counted from 0 for the first word accepted in the unit, sits at plane bits [16k+15:16k], with word bit 0 at plane bit 16k.
- R2: In plane-to-word mode, one accepted plane leaves as exactly 16 words, word 0 first. Word k equals plane bits [16k+15:16k].
- R3: There are two halves. While the drain side holds an unconsumed unit, the fill side still accepts one more complete unit. When the drain side takes the last beat of a unit while the other half is full, the next unit is valid in the following cycle with no idle cycle.
- R4: While drainValid is high and drainReady is low, drainValid stays high and drainData stays unchanged. drainValid falls only after a drain handshake.
- R5: fillReady is low while both halves hold units. Data offered during that time is not taken and does not change the stored units. fillReady falls only after a fill handshake.
- R6: The drain side is never valid for a half that is only partly filled. With the drain half empty, drainValid is still low in the cycle after the edge that takes the final fill beat, and is high in the cycle after that.
- R7: Asserting rstN low (asynchronous, active low) empties both halves, including any partial fill. Afterwards fillReady is 1 and drainValid is 0, and the next complete unit comes out intact and alone.
- R8: Units leave in the order in which they were filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| fillData | input | 16 (word-to-plane) or 256 (plane-to-word) | Data offered on the fill side |
| fillValid | input | 1 | Fill-side data is valid |
| fillReady | output | 1 | Fill side can take a beat |
| drainData | output | 256 (word-to-plane) or 16 (plane-to-word) | Data presented on the drain side |
| drainValid | output | 1 | Drain-side data is valid |
| drainReady | input | 1 | Consumer takes the drain beat |

## Verification
The bench goes after the points where the two halves change roles.

- **Completion of a fill.** It checks that drainValid stays low until the final beat of a unit has been taken, and that it rises exactly two cycles later. A design that swapped early would expose a half-filled plane. One that counted beats wrongly would show words in the wrong lanes.
- **Both halves occupied.** It fills both halves with the drain side stalled, then holds junk on the fill side. A buffer that did not drop fillReady, or that wrote while it was not ready, would corrupt the waiting unit.
- **Back-to-back drains.** It checks for a bubble or a repeat when the drain side consumes one unit while the other is waiting.
- **Reset in mid-fill.** It resets after a partial fill and checks that the stale words are discarded.

Streams with stalls on both sides then check ordering and lane placement in both directions.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  // Which way the instance turns data.
  typedef enum logic {
    CTB_WORD_TO_PLANE = 1'b0,
    CTB_PLANE_TO_WORD = 1'b1
  } ctbDir_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrEn;     // fill handshake this cycle
    logic fillSel;  // half currently being filled; the other half drains
  } ctbStrobe_t;

endpackage

// File: rtl/ctb_ctrl.sv
module ctb_ctrl
  import ctb_pkg::*;
#(
  parameter ctbDir_e DIR = CTB_WORD_TO_PLANE,
  parameter int NUM_WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  output logic             fillReady,
  output logic             drainValid,
  input  logic             drainReady,
  output ctbStrobe_t       strobe,
  output logic [IDX_W-1:0] beatIdx
);

  localparam bit W2P = (DIR == CTB_WORD_TO_PLANE);
  localparam int FILL_BEATS  = W2P ? NUM_WORDS : 1;
  localparam int DRAIN_BEATS = W2P ? 1 : NUM_WORDS;
  localparam logic [IDX_W-1:0] FILL_LAST  = IDX_W'(FILL_BEATS - 1);
  localparam logic [IDX_W-1:0] DRAIN_LAST = IDX_W'(DRAIN_BEATS - 1);

  logic [IDX_W-1:0] fillCnt;
  logic [IDX_W-1:0] drainCnt;
  logic             fillFull;
  logic             drainFull;
  logic             fillSel;

  logic fillFire;
  logic drainFire;
  logic fillLast;
  logic drainLast;
  logic swapHalves;

  always_comb begin
    fillFire   = fillValid && !fillFull;
    drainFire  = drainFull && drainReady;
    fillLast   = fillFire && (fillCnt == FILL_LAST);
    drainLast  = drainFire && (drainCnt == DRAIN_LAST);
    // Roles change only with a complete fill half and an empty (or emptying) drain half.
    swapHalves = fillFull && (!drainFull || drainLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt   <= '0;
      drainCnt  <= '0;
      fillFull  <= 1'b0;
      drainFull <= 1'b0;
      fillSel   <= 1'b0;
    end else begin
      if (fillFire) begin
        fillCnt <= fillLast ? '0 : fillCnt + 1'b1;
      end
      if (fillLast) begin
        fillFull <= 1'b1;
      end else if (swapHalves) begin
        fillFull <= 1'b0;
      end
      if (swapHalves) begin
        fillSel <= ~fillSel;
      end
      if (drainFire) begin
        drainCnt <= drainLast ? '0 : drainCnt + 1'b1;
      end
      if (swapHalves) begin
        drainFull <= 1'b1;
      end else if (drainLast) begin
        drainFull <= 1'b0;
      end
    end
  end

  assign fillReady      = !fillFull;
  assign drainValid     = drainFull;
  assign strobe.wrEn    = fillFire;
  assign strobe.fillSel = fillSel;

  // The multi-beat side owns the datapath index.
  generate
    if (W2P) begin : g_idxFill
      assign beatIdx = fillCnt;
    end else begin : g_idxDrain
      assign beatIdx = drainCnt;
    end
  endgenerate

endmodule

// File: rtl/ctb_datapath.sv
module ctb_datapath
  import ctb_pkg::*;
#(
  parameter ctbDir_e DIR = CTB_WORD_TO_PLANE,
  parameter int WORD_W = 16,
  parameter int NUM_WORDS = 16,
  parameter int IDX_W = 4,
  parameter int PLANE_W = WORD_W * NUM_WORDS,
  parameter int FILL_W = WORD_W,
  parameter int DRAIN_W = PLANE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctbStrobe_t         strobe,
  input  logic [IDX_W-1:0]   beatIdx,
  input  logic [FILL_W-1:0]  fillData,
  output logic [DRAIN_W-1:0] drainData
);

  localparam int NUM_HALVES = 2;

  logic [PLANE_W-1:0] bankQ [NUM_HALVES];
  logic               drainSel;

  assign drainSel = ~strobe.fillSel;

  generate
    if (DIR == CTB_WORD_TO_PLANE) begin : g_w2p
      // Words land in their lane of the filling half.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int h = 0; h < NUM_HALVES; h++) begin
            bankQ[h] <= '0;
          end
        end else if (strobe.wrEn) begin
          bankQ[strobe.fillSel][int'(beatIdx) * WORD_W +: WORD_W] <= fillData;
        end
      end
      assign drainData = bankQ[drainSel];
    end else begin : g_p2w
      // A whole plane lands at once; words are picked out on the way out.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int h = 0; h < NUM_HALVES; h++) begin
            bankQ[h] <= '0;
          end
        end else if (strobe.wrEn) begin
          bankQ[strobe.fillSel] <= fillData;
        end
      end
      assign drainData = bankQ[drainSel][int'(beatIdx) * WORD_W +: WORD_W];
    end
  endgenerate

endmodule

// File: rtl/corner_turn_buf.sv
module corner_turn_buf
  import ctb_pkg::*;
#(
  parameter ctbDir_e DIR = CTB_WORD_TO_PLANE,
  parameter int WORD_W = 16,
  parameter int NUM_WORDS = 16,
  localparam int PLANE_W = WORD_W * NUM_WORDS,
  localparam int FILL_W  = (DIR == CTB_WORD_TO_PLANE) ? WORD_W : PLANE_W,
  localparam int DRAIN_W = (DIR == CTB_WORD_TO_PLANE) ? PLANE_W : WORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FILL_W-1:0]  fillData,
  input  logic               fillValid,
  output logic               fillReady,
  output logic [DRAIN_W-1:0] drainData,
  output logic               drainValid,
  input  logic               drainReady
);

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  ctbStrobe_t       strobe;
  logic [IDX_W-1:0] beatIdx;

  ctb_ctrl #(
    .DIR      (DIR),
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .fillValid (fillValid),
    .fillReady (fillReady),
    .drainValid(drainValid),
    .drainReady(drainReady),
    .strobe    (strobe),
    .beatIdx   (beatIdx)
  );

  ctb_datapath #(
    .DIR      (DIR),
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W),
    .PLANE_W  (PLANE_W),
    .FILL_W   (FILL_W),
    .DRAIN_W  (DRAIN_W)
  ) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .beatIdx  (beatIdx),
    .fillData (fillData),
    .drainData(drainData)
  );

endmodule

// File: rtl/ctb_checker.sv
module ctb_checker
  import ctb_pkg::*;
#(
  parameter ctbDir_e DIR = CTB_WORD_TO_PLANE,
  parameter int WORD_W = 16,
  parameter int NUM_WORDS = 16,
  localparam int PLANE_W = WORD_W * NUM_WORDS,
  localparam int DRAIN_W = (DIR == CTB_WORD_TO_PLANE) ? PLANE_W : WORD_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               fillValid,
  input logic               fillReady,
  input logic [DRAIN_W-1:0] drainData,
  input logic               drainValid,
  input logic               drainReady
);

  localparam int unsigned FILL_WORDS  = (DIR == CTB_WORD_TO_PLANE) ? 1 : NUM_WORDS;
  localparam int unsigned DRAIN_WORDS = (DIR == CTB_WORD_TO_PLANE) ? NUM_WORDS : 1;
  localparam int unsigned CAP_WORDS   = 2 * NUM_WORDS;

  // Word-granular occupancy, tracked from the handshakes alone.
  int unsigned fillWords;
  int unsigned drainWords;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillWords  <= 0;
      drainWords <= 0;
    end else begin
      if (fillValid && fillReady) fillWords <= fillWords + FILL_WORDS;
      if (drainValid && drainReady) drainWords <= drainWords + DRAIN_WORDS;
    end
  end

  p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    drainValid && !drainReady |=> drainValid && $stable(drainData));

  p_valid_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drainValid) |-> $past(drainReady));

  p_ready_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fillReady) |-> $past(fillValid));

  p_handover_r3: assert property (@(posedge clk) disable iff (!rstN)
    !fillReady && !drainValid |=> drainValid && fillReady);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (drainWords <= fillWords) && (fillWords - drainWords <= CAP_WORDS));

  p_whole_unit_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drainValid) |-> (fillWords - drainWords == NUM_WORDS));

endmodule

bind corner_turn_buf ctb_checker #(
  .DIR      (DIR),
  .WORD_W   (WORD_W),
  .NUM_WORDS(NUM_WORDS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .fillValid (fillValid),
  .fillReady (fillReady),
  .drainData (drainData),
  .drainValid(drainValid),
  .drainReady(drainReady)
);

// File: tb/corner_turn_buf_tb_top.sv
module corner_turn_buf_tb_top;
  import ctb_pkg::*;

  localparam int WORD_W = 16;
  localparam int NUM_WORDS = 16;
  localparam int PLANE_W = WORD_W * NUM_WORDS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Word-to-plane instance (A).
  logic [WORD_W-1:0]  aFillData;
  logic               aFillValid, aFillReady;
  logic [PLANE_W-1:0] aDrainData;
  logic               aDrainValid, aDrainReady;
  // Plane-to-word instance (B).
  logic [PLANE_W-1:0] bFillData;
  logic               bFillValid, bFillReady;
  logic [WORD_W-1:0]  bDrainData;
  logic               bDrainValid, bDrainReady;

  corner_turn_buf #(.DIR(CTB_WORD_TO_PLANE)) dut_i (
    .clk(clk), .rstN(rstN),
    .fillData(aFillData), .fillValid(aFillValid), .fillReady(aFillReady),
    .drainData(aDrainData), .drainValid(aDrainValid), .drainReady(aDrainReady));

  corner_turn_buf #(.DIR(CTB_PLANE_TO_WORD)) dutP2w_i (
    .clk(clk), .rstN(rstN),
    .fillData(bFillData), .fillValid(bFillValid), .fillReady(bFillReady),
    .drainData(bDrainData), .drainValid(bDrainValid), .drainReady(bDrainReady));

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req,
                       input logic [PLANE_W-1:0] act, input logic [PLANE_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] wv(input int seed, input int k);
    return WORD_W'(seed * 40503 + k * 4099 + 17) ^ WORD_W'(k << 8);
  endfunction

  function automatic logic [PLANE_W-1:0] planeOf(input int seed);
    logic [PLANE_W-1:0] p;
    for (int k = 0; k < NUM_WORDS; k++) p[k*WORD_W +: WORD_W] = wv(seed, k);
    return p;
  endfunction

  // ---------------- handshake helpers ----------------
  task automatic pushWordA(input logic [WORD_W-1:0] w, input int gap);
    repeat (gap) begin @(negedge clk); aFillValid = 1'b0; end
    @(negedge clk); aFillData = w; aFillValid = 1'b1;
    while (!aFillReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idleFillA();
    @(negedge clk); aFillValid = 1'b0;
  endtask

  task automatic pushUnitA(input int seed, input int gap);
    for (int k = 0; k < NUM_WORDS; k++) pushWordA(wv(seed, k), gap);
  endtask

  task automatic pullPlaneA(output logic [PLANE_W-1:0] p, input int gap);
    repeat (gap) begin @(negedge clk); aDrainReady = 1'b0; end
    @(negedge clk); aDrainReady = 1'b1;
    while (!aDrainValid) @(negedge clk);
    p = aDrainData;
    @(posedge clk);
  endtask

  task automatic idleDrainA();
    @(negedge clk); aDrainReady = 1'b0;
  endtask

  task automatic pushPlaneB(input logic [PLANE_W-1:0] p, input int gap);
    repeat (gap) begin @(negedge clk); bFillValid = 1'b0; end
    @(negedge clk); bFillData = p; bFillValid = 1'b1;
    while (!bFillReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idleFillB();
    @(negedge clk); bFillValid = 1'b0;
  endtask

  task automatic pullWordB(output logic [WORD_W-1:0] w, input int gap);
    repeat (gap) begin @(negedge clk); bDrainReady = 1'b0; end
    @(negedge clk); bDrainReady = 1'b1;
    while (!bDrainValid) @(negedge clk);
    w = bDrainData;
    @(posedge clk);
  endtask

  task automatic idleDrainB();
    @(negedge clk); bDrainReady = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    aFillValid = 1'b0; aDrainReady = 1'b0;
    bFillValid = 1'b0; bDrainReady = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    check(aFillReady == 1'b1, "R7 w2p fillReady after reset", PLANE_W'(aFillReady), 1);
    check(aDrainValid == 1'b0, "R7 w2p drainValid after reset", PLANE_W'(aDrainValid), 0);
    check(bFillReady == 1'b1, "R7 p2w fillReady after reset", PLANE_W'(bFillReady), 1);
    check(bDrainValid == 1'b0, "R7 p2w drainValid after reset", PLANE_W'(bDrainValid), 0);
  endtask

  task automatic testW2pBasic();
    logic [PLANE_W-1:0] p;
    for (int k = 0; k < NUM_WORDS - 1; k++) pushWordA(wv(1, k), 0);
    idleFillA();
    check(aDrainValid == 1'b0, "R6 partial unit not presented", PLANE_W'(aDrainValid), 0);
    pushWordA(wv(1, NUM_WORDS - 1), 0);
    @(negedge clk); aFillValid = 1'b0;
    check(aDrainValid == 1'b0, "R6 valid low one cycle after last beat", PLANE_W'(aDrainValid), 0);
    check(aFillReady == 1'b0, "R6 fill half held full before handover", PLANE_W'(aFillReady), 0);
    @(negedge clk);
    check(aDrainValid == 1'b1, "R6 valid high two cycles after last beat", PLANE_W'(aDrainValid), 1);
    check(aFillReady == 1'b1, "R3 fill half free after handover", PLANE_W'(aFillReady), 1);
    pullPlaneA(p, 0);
    idleDrainA();
    check(p == planeOf(1), "R1 word lanes in plane", p, planeOf(1));
  endtask

  task automatic testW2pDouble();
    logic [PLANE_W-1:0] p, q, snap;
    aDrainReady = 1'b0;
    pushUnitA(2, 0);
    pushUnitA(3, 0);
    idleFillA();
    check(aFillReady == 1'b0, "R5 ready low with both halves full", PLANE_W'(aFillReady), 0);
    aFillData = 16'hDEAD; aFillValid = 1'b1;
    repeat (4) @(negedge clk);
    check(aFillReady == 1'b0, "R5 ready stays low while offered data", PLANE_W'(aFillReady), 0);
    aFillValid = 1'b0;
    snap = aDrainData;
    repeat (3) @(negedge clk);
    check(aDrainValid && (aDrainData == snap), "R4 drain held under backpressure", aDrainData, snap);
    pullPlaneA(p, 0);
    @(negedge clk);
    check(aDrainValid == 1'b1, "R3 no bubble between units", PLANE_W'(aDrainValid), 1);
    q = aDrainData;
    @(posedge clk);
    idleDrainA();
    check(p == planeOf(2), "R8 first unit first", p, planeOf(2));
    check(q == planeOf(3), "R5 second unit untouched by stalled data", q, planeOf(3));
    @(negedge clk);
    check(!aDrainValid && aFillReady, "R3 both halves empty after drain",
          PLANE_W'({aDrainValid, aFillReady}), PLANE_W'(2'b01));
  endtask

  task automatic testW2pReset();
    logic [PLANE_W-1:0] p;
    for (int k = 0; k < 10; k++) pushWordA(wv(4, k), 0);
    idleFillA();
    doReset();
    check(aFillReady && !aDrainValid, "R7 partial fill discarded by reset",
          PLANE_W'({aFillReady, aDrainValid}), PLANE_W'(2'b10));
    pushUnitA(5, 0);
    idleFillA();
    pullPlaneA(p, 0);
    idleDrainA();
    check(p == planeOf(5), "R7 first unit after reset intact", p, planeOf(5));
    @(negedge clk);
    check(aDrainValid == 1'b0, "R7 no stale unit after reset", PLANE_W'(aDrainValid), 0);
  endtask

  task automatic testW2pStream();
    fork
      begin
        for (int u = 0; u < 4; u++) pushUnitA(10 + u, u % 2);
        idleFillA();
      end
      begin
        for (int u = 0; u < 4; u++) begin
          logic [PLANE_W-1:0] p;
          pullPlaneA(p, (u == 1) ? 5 : 0);
          check(p == planeOf(10 + u), "R1 R8 stream unit", p, planeOf(10 + u));
        end
        idleDrainA();
      end
    join
  endtask

  task automatic testP2wBasic();
    logic [WORD_W-1:0] w, snap;
    pushPlaneB(planeOf(20), 0);
    idleFillB();
    repeat (3) @(negedge clk);
    snap = bDrainData;
    repeat (3) @(negedge clk);
    check(bDrainValid && (bDrainData == snap), "R4 p2w word held under backpressure",
          PLANE_W'(bDrainData), PLANE_W'(snap));
    for (int k = 0; k < NUM_WORDS; k++) begin
      pullWordB(w, 0);
      check(w == wv(20, k), "R2 p2w word order and lanes", PLANE_W'(w), PLANE_W'(wv(20, k)));
    end
    idleDrainB();
    check(bDrainValid == 1'b0, "R2 exactly sixteen words per plane", PLANE_W'(bDrainValid), 0);
  endtask

  task automatic testP2wDouble();
    logic [WORD_W-1:0] w;
    bDrainReady = 1'b0;
    pushPlaneB(planeOf(40), 0);
    pushPlaneB(planeOf(41), 0);
    idleFillB();
    check(bFillReady == 1'b0, "R5 p2w ready low with two planes held", PLANE_W'(bFillReady), 0);
    for (int i = 0; i < 2 * NUM_WORDS; i++) begin
      pullWordB(w, 0);
      check(w == wv(40 + i / NUM_WORDS, i % NUM_WORDS), "R8 p2w plane order",
            PLANE_W'(w), PLANE_W'(wv(40 + i / NUM_WORDS, i % NUM_WORDS)));
    end
    idleDrainB();
  endtask

  task automatic testP2wStream();
    fork
      begin
        for (int u = 0; u < 4; u++) pushPlaneB(planeOf(30 + u), u);
        idleFillB();
      end
      begin
        for (int i = 0; i < 4 * NUM_WORDS; i++) begin
          logic [WORD_W-1:0] w;
          pullWordB(w, (i % 7 == 3) ? 2 : 0);
          check(w == wv(30 + i / NUM_WORDS, i % NUM_WORDS), "R2 R4 R8 p2w stream",
                PLANE_W'(w), PLANE_W'(wv(30 + i / NUM_WORDS, i % NUM_WORDS)));
        end
        idleDrainB();
      end
    join
  endtask

  initial begin
    aFillData = '0; aFillValid = 1'b0; aDrainReady = 1'b0;
    bFillData = '0; bFillValid = 1'b0; bDrainReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testW2pBasic();
    testW2pDouble();
    testW2pReset();
    testW2pStream();
    testP2wBasic();
    testP2wDouble();
    testP2wStream();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R3 act=hung exp=complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule